// File: doc/BRIEF.md
# Multi-Register Vector Load/Store Sequencer

This block carries out one transfer between a byte-addressed memory and a file of eight 512-bit vector registers. A command is a 64-bit operand word plus a one-bit direction (load or store). The operand holds a 56-bit byte pointer, a 3-bit starting register index and flag bits. The sequencer turns the command into one, two or four beats of 64 bytes. Beat k uses address pointer + 64·k. Its register index is the start index plus k times a stride, taken modulo 8. The stride is 1 for a consecutive run, 4 for a strided pair and 2 for a strided quad.

On a load beat the block issues a read request, then waits for the response and writes the returned word into the register file in the cycle the response is seen. On a store beat it reads the register combinationally and sends the word with a write request. Store beats are posted: a store beat ends when its request handshakes. A parameter `VERSION` (1, 2 or 3) selects which load flags are honoured. Flags that are not honoured act as zero.

Back-pressure rules: the command port takes a command only while `cmd_ready` is high, and that is only when the block is idle. Once `mem_req_valid` is raised it stays high, with address, direction and data unchanged, until `mem_req_ready` is seen. `mem_rsp_ready` is high only while a load beat waits for its response. A response that arrives at any other time is not consumed.

Top module: `vls_xfer_seq`

## Requirements
- R1: `cmd_ready` equals the inverse of `busy`. `busy` rises in the cycle after a properly aligned command is accepted and falls in the cycle after the last beat completes. Out of reset, `busy`, `fault`, `mem_req_valid` and `rf_we` are 0 and `cmd_ready` is 1.
- R2: With operand bit 62 clear, exactly one beat runs. It uses the pointer (bits 55:0) at any byte alignment, and its register index is operand bits 58:56.
- R3: A multiple load (bit 62 set, no strided option) runs two beats to registers n and n+1 modulo 8. If bit 60 is set and VERSION is 2 or more, it runs four beats to n..n+3 modulo 8.
- R4: With VERSION 3, a multiple load with bit 61 set uses a stride: a pair goes to n and (n+4) mod 8, and a quad (bit 60 set) goes to n, n+2, n+4 and n+6, all modulo 8.
- R5: Beat k requests address pointer + 64·k, modulo 2^56, and every beat moves one 512-bit word.
- R6: A store ignores bits 61:59 and bit 63. A single store or a pair store (n, n+1 mod 8) sends `rf_rdata` of the beat's register as `mem_req_wdata`, with `mem_req_write` = 1.
- R7: A multi-register command whose pointer bits 6:0 are not all zero raises `fault` for exactly the one cycle after acceptance. It issues no request and no register write, and `busy` stays low.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high with the same address, direction and write data.
- R9: A load beat writes the register file (`rf_we` = 1, `rf_wdata` = `mem_rsp_rdata`) only in a cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high. No new request is issued in that cycle.
- R10: With VERSION 1, loads ignore bits 60 and 61, so a multiple load always writes the consecutive pair n, n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle if valid |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_operand | input | 64 | Pointer, register index and flags |
| busy | output | 1 | A transfer is in progress |
| fault | output | 1 | One-cycle pulse for a misaligned multi-register command |
| mem_req_valid | output | 1 | Memory beat request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | 56 | Byte address of the beat |
| mem_req_wdata | output | 512 | Write data of a store beat |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waits for read data |
| mem_rsp_rdata | input | 512 | Read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 512 | Register file write data |
| rf_raddr | output | 3 | Register file read index (combinational read) |
| rf_rdata | input | 512 | Register file read data |

## Verification
The hardest situation to reach from the ports is a stalled request in the middle of a multi-beat transfer, combined with a wrap of the register index past 7 under a stride. The bench drives every direction, every start index and every combination of bits 62:60, with both aligned and misaligned pointers. During the sweep a pseudo-random sequence withholds `mem_req_ready` and delays load responses by zero to three cycles. A second instance built with VERSION 1 receives loads with every flag set, to show that those flags are ignored.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int PTR_W   = 56;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 512;
  localparam int BEAT_W  = 2;
  localparam int CNT_W   = BEAT_W + 1;
  localparam int BLK_LSB = 6;   // 64-byte beat
  localparam int PAIR_AL = 7;   // 128-byte alignment for multi-register transfers

  // operand bit positions
  localparam int B_MULTI = 62;
  localparam int B_STRD  = 61;
  localparam int B_QUAD  = 60;
  localparam int B_IDX   = 56;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} seq_state_t;

  typedef struct packed {
    logic             store;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] stride;
    logic [CNT_W-1:0] beats;
    logic [PTR_W-1:0] ptr;
    logic             misalign;
  } xfer_plan_t;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
#(
  parameter int VERSION = 3
) (
  input  logic        op_store,
  input  logic [63:0] operand,
  output xfer_plan_t  plan
);
  localparam bit HAS_QUAD = (VERSION >= 2);
  localparam bit HAS_STRD = (VERSION >= 3);

  logic multi, quad, strided;

  always_comb begin
    multi   = operand[B_MULTI];
    quad    = multi && !op_store && HAS_QUAD && operand[B_QUAD];
    strided = multi && !op_store && HAS_STRD && operand[B_STRD];

    plan.store    = op_store;
    plan.base     = operand[B_IDX +: IDX_W];
    plan.ptr      = operand[PTR_W-1:0];
    plan.beats    = !multi ? CNT_W'(1) : (quad ? CNT_W'(4) : CNT_W'(2));
    plan.stride   = !strided ? IDX_W'(1) : (quad ? IDX_W'(2) : IDX_W'(4));
    plan.misalign = multi && (operand[PAIR_AL-1:0] != '0);
  end
endmodule

// File: rtl/vls_beat_map.sv
module vls_beat_map
  import vls_pkg::*;
(
  input  logic [IDX_W-1:0]  base,
  input  logic [IDX_W-1:0]  stride,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BEAT_W-1:0] beat,
  output logic [IDX_W-1:0]  idx,
  output logic [PTR_W-1:0]  addr
);
  logic [IDX_W+BEAT_W-1:0] step;

  always_comb begin
    step = (IDX_W+BEAT_W)'(stride) * (IDX_W+BEAT_W)'(beat);
    idx  = base + step[IDX_W-1:0];          // wraps modulo 8
    addr = ptr + {{(PTR_W-BEAT_W-BLK_LSB){1'b0}}, beat, {BLK_LSB{1'b0}}};
  end
endmodule

// File: rtl/vls_xfer_seq.sv
module vls_xfer_seq
  import vls_pkg::*;
#(
  parameter int VERSION = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_store,
  input  logic [63:0]         cmd_operand,
  output logic                busy,
  output logic                fault,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [PTR_W-1:0]    mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [DATA_W-1:0]   mem_rsp_rdata,
  output logic                rf_we,
  output logic [IDX_W-1:0]    rf_waddr,
  output logic [DATA_W-1:0]   rf_wdata,
  output logic [IDX_W-1:0]    rf_raddr,
  input  logic [DATA_W-1:0]   rf_rdata
);
  seq_state_t        state_q;
  xfer_plan_t        dec, plan_q;
  logic [BEAT_W-1:0] beat_q;
  logic              fault_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [PTR_W-1:0]  cur_addr;
  logic              last_beat;

  vls_decode #(.VERSION(VERSION)) u_dec (
    .op_store (cmd_store),
    .operand  (cmd_operand),
    .plan     (dec)
  );

  vls_beat_map u_map (
    .base   (plan_q.base),
    .stride (plan_q.stride),
    .ptr    (plan_q.ptr),
    .beat   (beat_q),
    .idx    (cur_idx),
    .addr   (cur_addr)
  );

  assign last_beat = (CNT_W'(beat_q) == plan_q.beats - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      plan_q  <= '0;
      beat_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          if (dec.misalign) begin
            fault_q <= 1'b1;
          end else begin
            plan_q  <= dec;
            beat_q  <= '0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) begin
          if (!plan_q.store) begin
            state_q <= ST_RSP;
          end else if (last_beat) begin
            state_q <= ST_IDLE;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        ST_RSP: if (mem_rsp_valid) begin
          if (last_beat) begin
            state_q <= ST_IDLE;
          end else begin
            beat_q  <= beat_q + BEAT_W'(1);
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready     = (state_q == ST_IDLE);
    busy          = (state_q != ST_IDLE);
    fault         = fault_q;
    mem_req_valid = (state_q == ST_REQ);
    mem_req_write = plan_q.store;
    mem_req_addr  = cur_addr;
    rf_raddr      = cur_idx;
    mem_req_wdata = plan_q.store ? rf_rdata : '0;
    mem_rsp_ready = (state_q == ST_RSP);
    rf_we         = mem_rsp_ready && mem_rsp_valid;
    rf_waddr      = cur_idx;
    rf_wdata      = mem_rsp_rdata;
  end

  // R1: no command taken while a transfer runs
  a_r1_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R8: a stalled request holds its contents
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R5: each request after the first in a transfer is 64 bytes further on
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && $past(busy) &&
     ($past(mem_req_valid && mem_req_ready) || $past(mem_rsp_ready))) |->
      (mem_req_addr == $past(mem_req_addr) + PTR_W'(64)));

  // R9: register writes never overlap an outstanding request
  a_r9_we_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!mem_req_valid && mem_rsp_valid && busy));

  // R7: a fault pulse leaves the block idle
  a_r7_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!busy && !mem_req_valid && !rf_we));
endmodule

// File: tb/vls_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module vls_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         cmd_valid = 1'b0, cmd_store = 1'b0;
  logic [63:0]  cmd_operand = '0;
  logic         cmd_ready, busy, fault;
  logic         mem_req_valid, mem_req_write, mem_rsp_ready;
  logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [55:0]  mem_req_addr;
  logic [511:0] mem_req_wdata, mem_rsp_rdata = '0, rf_wdata, rf_rdata;
  logic         rf_we;
  logic [2:0]   rf_waddr, rf_raddr;

  logic [511:0] regs [8];
  assign rf_rdata = regs[rf_raddr];

  vls_xfer_seq #(.VERSION(3)) dut_i (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_store, .cmd_operand,
    .busy, .fault, .mem_req_valid, .mem_req_ready, .mem_req_write,
    .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_ready,
    .mem_rsp_rdata, .rf_we, .rf_waddr, .rf_wdata, .rf_raddr, .rf_rdata);

  // second instance with VERSION 1; memory always ready, data always present
  logic         v1_cmd_valid = 1'b0, v1_cmd_store = 1'b0;
  logic [63:0]  v1_operand = '0;
  logic         v1_cmd_ready, v1_busy, v1_fault, v1_req_valid, v1_req_write, v1_rsp_ready, v1_we;
  logic [55:0]  v1_req_addr;
  logic [511:0] v1_wdata_o, v1_rf_wdata;
  logic [2:0]   v1_waddr, v1_raddr;

  vls_xfer_seq #(.VERSION(1)) dut_v1 (
    .clk, .rst_n, .cmd_valid(v1_cmd_valid), .cmd_ready(v1_cmd_ready),
    .cmd_store(v1_cmd_store), .cmd_operand(v1_operand), .busy(v1_busy),
    .fault(v1_fault), .mem_req_valid(v1_req_valid), .mem_req_ready(1'b1),
    .mem_req_write(v1_req_write), .mem_req_addr(v1_req_addr),
    .mem_req_wdata(v1_wdata_o), .mem_rsp_valid(1'b1), .mem_rsp_ready(v1_rsp_ready),
    .mem_rsp_rdata(pat(v1_req_addr)), .rf_we(v1_we), .rf_waddr(v1_waddr),
    .rf_wdata(v1_rf_wdata), .rf_raddr(v1_raddr), .rf_rdata(512'h0));

  int n_chk = 0, n_fail = 0;

  function automatic logic [511:0] pat(input logic [55:0] a);
    logic [511:0] r;
    for (int j = 0; j < 8; j++) r[j*64 +: 64] = {a, 8'(j)} ^ 64'h5A5A_0000_0000_0000;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // event logs filled by the monitor
  logic [55:0]  lg_addr [8];
  logic         lg_wr   [8];
  logic [511:0] lg_wd   [8];
  logic [2:0]   lg_idx  [8];
  logic [511:0] lg_rd   [8];
  int n_req = 0, n_rf = 0, n_hold_err = 0, v1_n_rf = 0;
  logic [2:0]   v1_idx [8];
  logic         prev_stall = 1'b0;
  logic [55:0]  prev_addr = '0;
  logic         rd_pend = 1'b0;
  logic [55:0]  rd_addr = '0;
  int           rd_wait = 0;
  logic [7:0]   lfsr = 8'h5B;

  // monitor at falling edge
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) n_hold_err++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (n_req < 8) begin
          lg_addr[n_req] = mem_req_addr; lg_wr[n_req] = mem_req_write; lg_wd[n_req] = mem_req_wdata;
        end
        n_req++;
        if (!mem_req_write) begin rd_pend = 1'b1; rd_addr = mem_req_addr; rd_wait = int'(lfsr[2:1]); end
      end
      if (rf_we) begin
        if (n_rf < 8) begin lg_idx[n_rf] = rf_waddr; lg_rd[n_rf] = rf_wdata; end
        n_rf++;
        regs[rf_waddr] = rf_wdata;
      end
      if (v1_we) begin
        if (v1_n_rf < 8) v1_idx[v1_n_rf] = v1_waddr;
        v1_n_rf++;
      end
    end
  end

  // memory driver, just after the rising edge
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready = lfsr[0] | lfsr[6];
    mem_rsp_valid = 1'b0;
    if (rd_pend) begin
      if (rd_wait == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_rdata = pat(rd_addr); rd_pend = 1'b0;
      end else rd_wait--;
    end
  end

  task automatic run_cmd(input bit st, input logic [63:0] op);
    logic [511:0] snap [8];
    bit multi, quad, strd, mis;
    int cnt, stride, n;
    logic [55:0] p;
    for (int i = 0; i < 8; i++) snap[i] = regs[i];
    multi = op[62];
    quad  = multi && !st && op[60];
    strd  = multi && !st && op[61];
    cnt    = !multi ? 1 : (quad ? 4 : 2);
    stride = !strd ? 1 : (quad ? 2 : 4);
    n = int'(op[58:56]);
    p = op[55:0];
    mis = multi && (p[6:0] != 0);
    n_req = 0; n_rf = 0; n_hold_err = 0;
    cmd_store = st; cmd_operand = op; cmd_valid = 1'b1;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
    chk(fault == mis, "R7 fault pulse", 512'(fault), 512'(mis));
    chk(busy == !mis && cmd_ready == mis, "R1 busy after accept", 512'(busy), 512'(!mis));
    @(negedge clk);
    chk(fault == 1'b0, "R7 fault one cycle", 512'(fault), 512'd0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    if (mis) begin
      chk(n_req == 0 && n_rf == 0, "R7 no beats", 512'(n_req + n_rf), 512'd0);
    end else begin
      chk(n_req == cnt, st ? "R6 request count" : "R3 R4 request count", 512'(n_req), 512'(cnt));
      chk(n_hold_err == 0, "R8 stalled request held", 512'(n_hold_err), 512'd0);
      chk(n_rf == (st ? 0 : cnt), "R9 register write count", 512'(n_rf), 512'(st ? 0 : cnt));
      for (int k = 0; k < cnt && k < n_req; k++) begin
        logic [55:0] ea;
        logic [2:0] ei;
        ea = p + 56'(64 * k);
        ei = 3'((n + stride * k) % 8);
        chk(lg_addr[k] == ea, "R5 beat address", 512'(lg_addr[k]), 512'(ea));
        chk(lg_wr[k] == st, "R6 direction", 512'(lg_wr[k]), 512'(st));
        if (st) chk(lg_wd[k] == snap[ei], "R6 store data", lg_wd[k], snap[ei]);
        else if (k < n_rf) begin
          chk(lg_idx[k] == ei, strd ? "R4 strided index" : (multi ? "R3 index" : "R2 index"),
              512'(lg_idx[k]), 512'(ei));
          chk(lg_rd[k] == pat(ea), "R9 load data", lg_rd[k], pat(ea));
        end
      end
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = {8{64'h0123_4567_0000_0000 | 64'(i)}};
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!busy && cmd_ready && !fault && !mem_req_valid && !rf_we, "R1 reset state",
        512'({busy, cmd_ready, fault, mem_req_valid, rf_we}), 512'b01000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int st = 0; st < 2; st++)
      for (int n = 0; n < 8; n++)
        for (int fl = 0; fl < 8; fl++)
          for (int mis = 0; mis < 2; mis++) begin
            logic [55:0] p;
            logic [7:0] off;
            off = (mis == 0) ? 8'h00 : ((fl % 2 == 1) ? 8'h40 : 8'h24);
            p = 56'h10_0000 + 56'((st * 64 + n * 8 + fl) * 512) + 56'(off);
            run_cmd(st[0], {1'(mis), 3'(fl), 1'(n % 2), 3'(n), p});
          end
    // R10: VERSION 1 ignores bits 60 and 61 on a load
    v1_n_rf = 0;
    v1_cmd_store = 1'b0; v1_operand = {4'b0111, 1'b0, 3'd6, 56'h2000}; v1_cmd_valid = 1'b1;
    @(posedge clk); #1 v1_cmd_valid = 1'b0;
    @(negedge clk);
    while (v1_busy) @(negedge clk);
    chk(v1_n_rf == 2, "R10 beat count", 512'(v1_n_rf), 512'd2);
    chk(v1_idx[0] == 3'd6 && v1_idx[1] == 3'd7, "R10 consecutive targets",
        512'({v1_idx[0], v1_idx[1]}), 512'({3'd6, 3'd7}));
    v1_n_rf = 0;
    v1_operand = {4'b0101, 1'b1, 3'd7, 56'h3000}; v1_cmd_valid = 1'b1;
    @(posedge clk); #1 v1_cmd_valid = 1'b0;
    @(negedge clk);
    while (v1_busy) @(negedge clk);
    chk(v1_n_rf == 2 && v1_idx[1] == 3'd0, "R10 wrap with quad flag ignored",
        512'({v1_n_rf[3:0], v1_idx[1]}), 512'({4'd2, 3'd0}));
    finish_run();
  end
endmodule